// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block sits between the byte-load controller of a non-volatile memory and its page buffer. It watches every write (an address and a data byte) the controller presents and decides, in the same cycle, whether that write may go on to the page buffer. It also holds a single mode bit that records whether software write protection is on.

Two command strings drive the mode. Both begin with the same two steps. A three-write string turns protection on and opens a window in which the data writes that follow are let through. A six-write string turns protection off. Command writes are consumed and never reach the buffer. While protection is on, a write that is not part of a command string is dropped. An expiry pulse from the byte-load window timer closes the window and drops any string that is half entered.

Top module: `swp_sequencer`

## Requirements
- R1: After reset `protOn` is 0, and the first write that is not a command step is accepted.
- R2: When protection is off and no string is in progress, a write whose (address, data) is not the first command step (0x1555, 0xAA) is accepted in the cycle `wrValid` is high.
- R3: A write that advances a command string is never accepted. The command steps are (0x1555,0xAA), (0x0AAA,0x55), then either (0x1555,0xA0), or (0x1555,0x80), (0x1555,0xAA), (0x0AAA,0x55), (0x1555,0x20).
- R4: Completing the three-write string (0x1555,0xAA), (0x0AAA,0x55), (0x1555,0xA0) sets `protOn` to 1 from the next cycle on.
- R5: After the three-write string, every write is accepted until `windowExpire` is seen.
- R6: With protection on and no window open, a write that is not the first command step is rejected.
- R7: While protection is on, a write that does not match the next expected step drops the string in progress and is rejected. A later data write then needs the full three-write string.
- R8: Completing the six-write string clears `protOn` from the next cycle on. Later plain writes are accepted.
- R9: `windowExpire` drops a partial string and closes an open window. When it comes in the same cycle as a write, the expiry is applied first and the write is judged from the idle state.
- R10: While protection is off, a write that breaks a string in progress is itself accepted. The command writes consumed before it are lost.
- R11: `wrAccept` is never high while `wrValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | A write transaction is present this cycle |
| wrAddr | input | 13 | Write address |
| wrData | input | 8 | Write data byte |
| windowExpire | input | 1 | One-cycle pulse: the byte-load window timer has run out |
| wrAccept | output | 1 | The present write may go to the page buffer |
| protOn | output | 1 | Software write protection is on |

## Verification
On every cycle the assertions check these points. The mode bit changes only on a strobe that completes a string. An open window lets each write through. A locked idle sequencer rejects plain writes. A write that advances a step is never accepted. `wrAccept` never rises without `wrValid`. Other behaviour depends on a whole history of writes, so only the bench scenarios can show it: the branch on the third write, strings broken part way in each mode, an expiry that lands in the same cycle as a write, and whether consumed command bytes are lost. The bench's reference model matches accumulated writes against the two strings as prefixes and checks these cases.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_S1,
    ST_S2,
    ST_OPEN,
    ST_D3,
    ST_D4,
    ST_D5
  } seqState_t;

  typedef struct packed {
    logic acceptWr;
    logic setProt;
    logic clrProt;
  } ctrlStrobe_t;

  typedef struct packed {
    logic stepA;
    logic stepB;
    logic stepEn;
    logic stepDis;
    logic stepOff;
  } stepHit_t;

  localparam int NUM_PATTERNS = 5;

endpackage

// File: rtl/swp_datapath.sv
module swp_datapath
  import swp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_HI = 13'h1555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 13'h0AAA,
  parameter logic [DATA_W-1:0] CODE_A = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_B = 8'h55,
  parameter logic [DATA_W-1:0] CODE_EN = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_DIS = 8'h80,
  parameter logic [DATA_W-1:0] CODE_OFF = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  ctrlStrobe_t       strobe,
  output stepHit_t          hit,
  output logic              protOn
);

  localparam int PAIR_W = ADDR_W + DATA_W;
  localparam logic [PAIR_W-1:0] PATTERN [NUM_PATTERNS] = '{
    {ADDR_HI, CODE_A},
    {ADDR_LO, CODE_B},
    {ADDR_HI, CODE_EN},
    {ADDR_HI, CODE_DIS},
    {ADDR_HI, CODE_OFF}
  };

  logic [PAIR_W-1:0] pair;
  logic [NUM_PATTERNS-1:0] hitVec;

  assign pair = {wrAddr, wrData};

  for (genvar k = 0; k < NUM_PATTERNS; k++) begin : g_cmp
    assign hitVec[k] = (pair == PATTERN[k]);
  end

  assign hit.stepA   = hitVec[0];
  assign hit.stepB   = hitVec[1];
  assign hit.stepEn  = hitVec[2];
  assign hit.stepDis = hitVec[3];
  assign hit.stepOff = hitVec[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protOn <= 1'b0;
    end else if (strobe.setProt) begin
      protOn <= 1'b1;
    end else if (strobe.clrProt) begin
      protOn <= 1'b0;
    end
  end

  a_r4_set_raises: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setProt |=> protOn);

  a_r8_clr_drops: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrProt |=> !protOn);

  a_r7_mode_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.setProt && !strobe.clrProt) |=> $stable(protOn));

endmodule

// File: rtl/swp_ctrl.sv
module swp_ctrl
  import swp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        windowExpire,
  input  stepHit_t    hit,
  input  logic        protOn,
  output ctrlStrobe_t strobe
);

  seqState_t st;
  seqState_t stNext;
  seqState_t stEff;
  logic      plainOk;

  assign stEff   = windowExpire ? ST_IDLE : st;
  assign plainOk = !protOn;

  always_comb begin
    stNext = stEff;
    strobe = '0;
    if (wrValid) begin
      stNext = ST_IDLE;
      unique case (stEff)
        ST_IDLE: begin
          if (hit.stepA) stNext = ST_S1;
          else           strobe.acceptWr = plainOk;
        end
        ST_S1: begin
          if (hit.stepB) stNext = ST_S2;
          else           strobe.acceptWr = plainOk;
        end
        ST_S2: begin
          if (hit.stepEn) begin
            stNext = ST_OPEN;
            strobe.setProt = 1'b1;
          end else if (hit.stepDis) begin
            stNext = ST_D3;
          end else begin
            strobe.acceptWr = plainOk;
          end
        end
        ST_D3: begin
          if (hit.stepA) stNext = ST_D4;
          else           strobe.acceptWr = plainOk;
        end
        ST_D4: begin
          if (hit.stepB) stNext = ST_D5;
          else           strobe.acceptWr = plainOk;
        end
        ST_D5: begin
          if (hit.stepOff) strobe.clrProt = 1'b1;
          else             strobe.acceptWr = plainOk;
        end
        ST_OPEN: begin
          stNext = ST_OPEN;
          strobe.acceptWr = 1'b1;
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  a_r11_accept_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptWr |-> wrValid);

  a_r5_window_passes: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_OPEN && wrValid && !windowExpire) |-> strobe.acceptWr);

  a_r6_locked_rejects: assert property (@(posedge clk) disable iff (!rstN)
    (protOn && st == ST_IDLE && wrValid) |-> !strobe.acceptWr);

  a_r3_step_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !windowExpire && st == ST_S1 && hit.stepB) |-> !strobe.acceptWr);

  a_r9_expire_clears: assert property (@(posedge clk) disable iff (!rstN)
    (windowExpire && !wrValid) |=> (st == ST_IDLE));

endmodule

// File: rtl/swp_sequencer.sv
module swp_sequencer
  import swp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              windowExpire,
  output logic              wrAccept,
  output logic              protOn
);

  ctrlStrobe_t strobe;
  stepHit_t    hit;

  swp_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .strobe(strobe),
    .hit   (hit),
    .protOn(protOn)
  );

  swp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .wrValid     (wrValid),
    .windowExpire(windowExpire),
    .hit         (hit),
    .protOn      (protOn),
    .strobe      (strobe)
  );

  assign wrAccept = strobe.acceptWr;

endmodule

// File: tb/sim_swp_sequencer.sv
module sim_swp_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 5000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        windowExpire = 1'b0;
  logic        wrAccept;
  logic        protOn;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  string curReq = "R1";

  logic [20:0] got [$];
  bit mProt = 0;
  bit mOpen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swp_sequencer u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .windowExpire(windowExpire),
    .wrAccept(wrAccept), .protOn(protOn)
  );

  function automatic logic [20:0] seqStep(input int which, input int i);
    logic [20:0] en [3];
    logic [20:0] dis [6];
    en  = '{{13'h1555, 8'hAA}, {13'h0AAA, 8'h55}, {13'h1555, 8'hA0}};
    dis = '{{13'h1555, 8'hAA}, {13'h0AAA, 8'h55}, {13'h1555, 8'h80},
            {13'h1555, 8'hAA}, {13'h0AAA, 8'h55}, {13'h1555, 8'h20}};
    return (which == 0) ? en[i] : dis[i];
  endfunction

  function automatic bit isPrefix(input logic [20:0] q [$], input int which);
    int len = (which == 0) ? 3 : 6;
    if (q.size() > len) return 0;
    for (int i = 0; i < q.size(); i++)
      if (q[i] != seqStep(which, i)) return 0;
    return 1;
  endfunction

  // Reference model, compared and advanced every falling edge.
  always @(negedge clk) begin
    bit expAcc;
    cycles++;
    vectors++;
    if (protOn !== mProt) begin
      miscompares++;
      $display("FAIL %s protOn act=%0b exp=%0b", curReq, protOn, mProt);
    end
    expAcc = 0;
    if (rstN) begin
      if (windowExpire) begin
        got.delete();
        mOpen = 0;
      end
      if (wrValid) begin
        if (mOpen) begin
          expAcc = 1;
        end else begin
          got.push_back({wrAddr, wrData});
          if (got.size() == 3 && isPrefix(got, 0)) begin
            mProt = 1; mOpen = 1; got.delete();
          end else if (got.size() == 6 && isPrefix(got, 1)) begin
            mProt = 0; got.delete();
          end else if (!isPrefix(got, 0) && !isPrefix(got, 1)) begin
            got.delete();
            expAcc = !mProt;
          end
        end
      end
      vectors++;
      if (wrAccept !== expAcc) begin
        miscompares++;
        $display("FAIL %s wrAccept act=%0b exp=%0b", curReq, wrAccept, expAcc);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      miscompares++;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    wrValid = 1'b0;
  endtask

  task automatic expire(input bit withWrite, input logic [12:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    windowExpire = 1'b1; wrValid = withWrite; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    windowExpire = 1'b0; wrValid = 1'b0;
  endtask

  task automatic enableSeq();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
  endtask

  task automatic disableSeq();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
  endtask

  initial begin
    curReq = "R1";
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    wr(13'h0010, 8'h33);

    curReq = "R2";
    wr(13'h1FFF, 8'h00); wr(13'h1555, 8'h55); wr(13'h0AAA, 8'hAA);

    curReq = "R11";
    @(posedge clk); #1 wrAddr = 13'h0044; wrData = 8'h12;
    repeat (2) @(posedge clk);

    curReq = "R10";
    wr(13'h1555, 8'hAA); wr(13'h0123, 8'h77);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h11);

    curReq = "R4";
    enableSeq();
    curReq = "R5";
    wr(13'h0200, 8'h5A); wr(13'h1555, 8'hAA); wr(13'h0201, 8'hC3);
    curReq = "R9";
    expire(0, '0, '0);

    curReq = "R6";
    wr(13'h0300, 8'h01); wr(13'h0AAA, 8'h55);

    curReq = "R7";
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h77);
    wr(13'h1555, 8'hA0); wr(13'h0301, 8'h02);

    curReq = "R3";
    enableSeq();
    wr(13'h0400, 8'hEE);
    expire(0, '0, '0);

    curReq = "R9";
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55);
    expire(0, '0, '0);
    wr(13'h1555, 8'hA0);
    wr(13'h1555, 8'hAA);
    expire(1, 13'h0AAA, 8'h55);
    enableSeq();
    expire(1, 13'h0500, 8'h09);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
    expire(0, '0, '0);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);

    curReq = "R8";
    disableSeq();
    wr(13'h0600, 8'h66); wr(13'h0601, 8'h67);

    curReq = "R2";
    disableSeq();
    wr(13'h0700, 8'h70);

    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule